// File: doc/BRIEF.md
# Read Data De-interleaver

This block sits on the read-data return path between a subordinate that may mix beats of different reads on one channel and a manager that expects every read to arrive as one unbroken burst. Beats come in over a valid/ready handshake, each tagged with a transaction ID. A beat may carry a different ID from the beat before it. Each beat is placed into a buffer owned by its ID, in arrival order.

A read is released only after its final beat has been stored. Completed reads are queued in the order their final beats arrived. The output then sends the read at the head of that queue, beat by beat, up to and including its final beat. Only after that does any other read start. Reads with different IDs can therefore leave in a different order from the one in which they were issued. Data, response, ID and the last flag pass through untouched.

The number of ID slots and the beats held per slot are parameters. No single read may be longer than one slot's depth.

Top module: `rd_deinterleave`

## Requirements
- R1: An input beat is accepted in any cycle where in_valid is high and the slot for its ID has room, whatever ID the previous beat had.
- R2: in_data, in_resp and in_id reach out_data, out_resp and out_id unchanged.
- R3: The beats of one read leave in the same order they were accepted.
- R4: Once a beat of a read has left with out_last low, the next beat sent carries the same ID. out_valid is high in the very next cycle, until the beat with out_last high has left.
- R5: Complete reads leave in the order in which their final beats were accepted. This may differ from issue order: a read whose final beat arrives earlier leaves first.
- R6: in_ready is low only when the slot named by in_id holds SLOT_DEPTH beats. Beats for other IDs are still accepted in that cycle.
- R7: out_last is high exactly on the output beat that was accepted with in_last high.
- R8: While out_valid is high and out_ready is low, out_valid, out_id, out_data, out_resp and out_last hold their values into the next cycle.
- R9: After reset, out_valid is low and in_ready is high.
- R10: No beat of a read is offered on the output until that read's final beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Slot of in_id can take the beat |
| in_id | input | ID_W | Transaction ID of the input beat |
| in_data | input | DATA_W | Read data |
| in_resp | input | RESP_W | Read response |
| in_last | input | 1 | Final beat of its read |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Manager takes the output beat |
| out_id | output | ID_W | Transaction ID of the output beat |
| out_data | output | DATA_W | Read data |
| out_resp | output | RESP_W | Read response |
| out_last | output | 1 | Final beat of the current read |

## Verification
Every cycle, the assertions check these properties:
- the output holds steady while stalled;
- a burst never switches ID before its final beat and never has a gap in valid;
- the read at the head of the queue always has buffered data;
- neither a slot buffer nor the completion queue is ever pushed while full.

Only the bench's scenarios can show the rest:
- data integrity and ordering within each ID;
- the release order of whole reads, including a later-issued read overtaking an earlier one;
- the placement of the last flag;
- that a full slot stalls only its own ID.

These are shown against a scoreboard fed with constrained-random interleaved traffic and with directed cases.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
  // Index width helper that never returns zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rdi_slot_fifo.sv
module rdi_slot_fifo
  import rdi_pkg::*;
#(
  parameter int W     = 35,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_data = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    end
    if (pop) begin
      rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage array: written only when enabled, no reset needed
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q] <= push_data;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rdi_out_select.sv
module rdi_out_select
  import rdi_pkg::*;
#(
  parameter int NUM = 4,
  parameter int W   = 35,
  parameter int IW  = 2
) (
  input  logic [NUM-1:0][W-1:0] heads,
  input  logic [IW-1:0]         sel,
  input  logic                  fire,
  output logic [W-1:0]          beat,
  output logic [NUM-1:0]        pop
);
  always_comb begin
    beat = '0;
    for (int i = 0; i < NUM; i++) begin
      if (sel == IW'(i)) beat = heads[i];
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_pop
    assign pop[g] = fire && (sel == IW'(g));
  end
endmodule

// File: rtl/rd_deinterleave.sv
module rd_deinterleave
  import rdi_pkg::*;
#(
  parameter int NUM_IDS    = 4,
  parameter int SLOT_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int RESP_W     = 2,
  localparam int ID_W      = idx_w(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  input  logic [RESP_W-1:0] in_resp,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] out_data,
  output logic [RESP_W-1:0] out_resp,
  output logic              out_last
);
  localparam int BEAT_W  = DATA_W + RESP_W + 1;
  localparam int Q_DEPTH = NUM_IDS * SLOT_DEPTH;

  logic [BEAT_W-1:0]              in_beat, out_beat;
  logic [NUM_IDS-1:0][BEAT_W-1:0] slot_head;
  logic [NUM_IDS-1:0]             slot_full, slot_empty, slot_push, slot_pop;
  logic                           in_fire, out_fire, id_ok;
  logic                           q_push, q_pop, q_full, q_empty;
  logic [ID_W-1:0]                q_head;

  assign in_beat  = {in_last, in_resp, in_data};
  assign id_ok    = (32'(in_id) < NUM_IDS);
  assign in_ready = id_ok && !slot_full[in_id];
  assign in_fire  = in_valid && in_ready;

  // One buffer per ID slot
  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    assign slot_push[g] = in_fire && (in_id == ID_W'(g));
    rdi_slot_fifo #(.W(BEAT_W), .DEPTH(SLOT_DEPTH)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (slot_push[g]),
      .push_data (in_beat),
      .pop       (slot_pop[g]),
      .head_data (slot_head[g]),
      .full      (slot_full[g]),
      .empty     (slot_empty[g])
    );
  end

  // Completion queue: IDs of reads whose final beat is stored
  assign q_push = in_fire && in_last;
  assign q_pop  = out_fire && out_last;

  rdi_slot_fifo #(.W(ID_W), .DEPTH(Q_DEPTH)) u_done (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (in_id),
    .pop       (q_pop),
    .head_data (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign out_valid = !q_empty;
  assign out_fire  = out_valid && out_ready;
  assign out_id    = q_head;

  rdi_out_select #(.NUM(NUM_IDS), .W(BEAT_W), .IW(ID_W)) u_sel (
    .heads (slot_head),
    .sel   (q_head),
    .fire  (out_fire),
    .beat  (out_beat),
    .pop   (slot_pop)
  );

  assign {out_last, out_resp, out_data} = out_beat;

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_data)
                                   && $stable(out_resp) && $stable(out_last)));
  assert_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !out_last) |=> (out_valid && out_id == $past(out_id)));
  assert_head_has_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !slot_empty[out_id]);
  assert_done_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (!q_full || q_pop));
endmodule

// File: tb/sim_rd_deinterleave.sv
module sim_rd_deinterleave;
  localparam int CLK_PERIOD = 10;
  localparam int NUM  = 4;
  localparam int DEP  = 16;
  localparam int DW   = 32;
  localparam int RW   = 2;
  localparam int IW   = 2;
  localparam int BW   = DW + RW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [IW-1:0] in_id, out_id;
  logic [DW-1:0] in_data, out_data;
  logic [RW-1:0] in_resp, out_resp;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_deinterleave #(.NUM_IDS(NUM), .SLOT_DEPTH(DEP), .DATA_W(DW), .RESP_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
    .in_resp(in_resp), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_data(out_data),
    .out_resp(out_resp), .out_last(out_last));

  int total = 0;
  int bad   = 0;
  logic [BW-1:0] exp_q [NUM][$];
  int unsigned   done_q[$];
  bit            mid_burst = 0;
  logic [IW-1:0] burst_id  = '0;
  bit            finished  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: called just after a negedge with inputs driven
  task automatic cycle(output bit acc);
    logic [BW-1:0] e;
    #1;
    acc = in_valid && in_ready;
    if (mid_burst) begin
      chk(out_valid, "R4 valid gap", 64'(out_valid), 64'd1);
      chk(out_id == burst_id, "R4 id switch", 64'(out_id), 64'(burst_id));
    end
    if (out_valid) begin
      if (done_q.size() == 0) begin
        chk(0, "R10 early output", 64'(out_valid), 64'd0);
      end else begin
        chk(32'(out_id) == done_q[0], "R5 read order", 64'(out_id), 64'(done_q[0]));
      end
    end
    if (out_valid && out_ready) begin
      if (exp_q[out_id].size() == 0) begin
        chk(0, "R3 unexpected beat", 64'(out_data), 64'd0);
      end else begin
        e = exp_q[out_id].pop_front();
        chk(out_data == e[DW-1:0], "R2/R3 data", 64'(out_data), 64'(e[DW-1:0]));
        chk(out_resp == e[DW+RW-1:DW], "R2 resp", 64'(out_resp), 64'(e[DW+RW-1:DW]));
        chk(out_last == e[BW-1], "R7 last", 64'(out_last), 64'(e[BW-1]));
      end
      mid_burst = !out_last;
      burst_id  = out_id;
      if (out_last && done_q.size() != 0) void'(done_q.pop_front());
    end
    if (acc) begin
      exp_q[in_id].push_back({in_last, in_resp, in_data});
      if (in_last) done_q.push_back(32'(in_id));
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input int id, input logic [DW-1:0] d, input logic [RW-1:0] r, input bit l);
    bit acc;
    in_valid = 1'b1; in_id = IW'(id); in_data = d; in_resp = r; in_last = l;
    do cycle(acc); while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit acc;
    out_ready = 1'b1;
    for (int k = 0; k < 200 && (out_valid || done_q.size() != 0); k++) cycle(acc);
    chk(done_q.size() == 0, "R5 drain", 64'(done_q.size()), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [DW-1:0] hold_d;
    int rem [NUM];
    int seq = 0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_id = '0; in_data = '0; in_resp = '0;
    in_last = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);

    // Directed: ID0 issued first, ID1 overtakes it (R5, R10, R1)
    send(0, 32'hA000_0000, 2'd0, 0);
    send(1, 32'hB000_0000, 2'd1, 0);
    send(0, 32'hA000_0001, 2'd0, 0);
    #1; chk(out_valid == 1'b0, "R10 nothing complete", 64'(out_valid), 64'd0);
    send(1, 32'hB000_0001, 2'd2, 1);
    #1;
    chk(out_valid == 1'b1, "R5 later read ready", 64'(out_valid), 64'd1);
    chk(out_id == 2'd1, "R5 overtaking id", 64'(out_id), 64'd1);
    hold_d = out_data;
    cycle(acc); cycle(acc);
    #1;
    chk(out_data == hold_d && out_valid, "R8 hold", 64'(out_data), 64'(hold_d));
    send(0, 32'hA000_0002, 2'd3, 1);
    drain();

    // Directed: fill ID2 slot, check per-slot backpressure (R6)
    out_ready = 1'b0;
    for (int k = 0; k < DEP; k++) send(2, 32'hC000_0000 + DW'(k), 2'd0, k == DEP - 1);
    in_valid = 1'b1; in_id = 2'd2; in_last = 1'b1; #1;
    chk(in_ready == 1'b0, "R6 full slot", 64'(in_ready), 64'd0);
    in_id = 2'd3; #1;
    chk(in_ready == 1'b1, "R6 other slot", 64'(in_ready), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    send(3, 32'hD000_0000, 2'd1, 1);
    drain();

    // Constrained random interleaved traffic
    for (int k = 0; k < NUM; k++) rem[k] = 0;
    for (int c = 0; c < 6000; c++) begin
      if (!in_valid) begin
        if ($urandom_range(3) != 0) begin
          int id = int'($urandom_range(NUM - 1));
          if (rem[id] == 0) rem[id] = int'($urandom_range(8, 1));
          in_valid = 1'b1; in_id = IW'(id);
          seq++;
          in_data = {8'(id), 24'(seq)};
          in_resp = RW'($urandom_range(3));
          in_last = (rem[id] == 1);
        end
      end
      out_ready = ($urandom_range(3) != 0);
      cycle(acc);
      if (acc) begin
        rem[in_id] = rem[in_id] - 1;
        in_valid = 1'b0;
      end
    end
    in_valid = 1'b0;
    // Close every open read so all data can drain
    for (int k = 0; k < NUM; k++) begin
      while (rem[k] > 0) begin
        seq++;
        send(k, {8'(k), 24'(seq)}, 2'd0, rem[k] == 1);
        rem[k] = rem[k] - 1;
      end
    end
    drain();
    for (int k = 0; k < NUM; k++)
      chk(exp_q[k].size() == 0, "R3 leftover", 64'(exp_q[k].size()), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule